// File: doc/BRIEF.md
# Serial Converter Port Emulator

This block is a cycle-based stand-in for the digital side of a 12-bit sampling converter with a three-wire serial port. It is used in verification wherever the real converter would sit on the board. A convert strobe, a shift clock and a serial configuration input come in. The result goes out on a serial data line that has an output enable, together with a sleep indicator and an early-release error flag. Two parallel channel-level buses replace the analog inputs. Each bus is one bit wider than the result, so that levels above full scale can be presented.

All inputs are sampled on the block's own clock, and edges on the strobe and the shift clock are found by comparing each input with its value one cycle earlier. Raising the strobe captures a code from the channel pair selected by the current configuration and starts a conversion that lasts a fixed number of clocks. After the strobe is lowered, the result is shifted out most-significant bit first. At the same time, a new channel configuration is shifted in. That configuration takes effect at the following conversion.

Top module: `conv_port_emu`

## Requirements
- R1: A conversion occupies CONV_CYC clock cycles, counted from the edge that sees the strobe high. If the strobe is lowered once that time has elapsed, the new code is shifted out and the error flag stays low.
- R2: If the strobe is still high when the conversion ends, `sleep` rises and stays high until the strobe falls. `sleep` and `sdo_oe` are never high together.
- R3: While the strobe is high, `sdo_oe` is 0 and `sdo` is 0. One cycle after a falling strobe edge is detected, `sdo_oe` is 1.
- R4: After the strobe falls, `sdo` shows bit 11 of the code. Each detected falling shift-clock edge advances the output to the next lower bit, and nothing else changes `sdo` while it is enabled.
- R5: Once bit 0 has been shifted past, every further falling shift-clock edge with the strobe low leaves `sdo` at 0.
- R6: The first two `sdi` values sampled on rising shift-clock edges after the strobe falls form the configuration. The first value is the single-ended flag and the second is the odd/sign flag. Later `sdi` values in the same cycle have no effect.
- R7: A configuration shifted in during a transfer has no effect on the code being shifted out in that transfer. It governs the next conversion only.
- R8: The code is captured at the rising strobe edge, and later level changes do not alter it. The captured code is computed as follows. Single-ended with odd=0 gives `ch0_lvl`. Single-ended with odd=1 gives `ch1_lvl`. Differential with odd=0 gives `ch0_lvl - ch1_lvl`. Differential with odd=1 gives `ch1_lvl - ch0_lvl`. A negative result gives 0 and a result above 4095 gives 4095.
- R9: If the strobe falls before CONV_CYC cycles have elapsed, `early_err` rises and the previous valid code is shifted out instead of the new one. The flag clears at the next rising strobe edge.
- R10: After reset, `sdo_oe`, `sdo`, `sleep` and `early_err` are 0, and the configuration is single-ended channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all inputs and state |
| rst_n | input | 1 | Active-low synchronous reset |
| conv | input | 1 | Convert strobe: high starts and holds a conversion, low enables the output |
| sck | input | 1 | Shift clock: falling edges advance `sdo`, rising edges sample `sdi` |
| sdi | input | 1 | Serial configuration input |
| ch0_lvl | input | RES+1 | Level presented on channel 0, in LSB units |
| ch1_lvl | input | RES+1 | Level presented on channel 1, in LSB units |
| sdo | output | 1 | Serial result bit, 0 while disabled |
| sdo_oe | output | 1 | Output enable for `sdo`; 0 means high-impedance |
| sleep | output | 1 | Conversion finished with the strobe still high |
| early_err | output | 1 | Strobe released before the conversion time elapsed |

## Verification
The bench builds the block with its defaults: RES=12 and CONV_CYC=8. The short conversion time makes every strobe hold length around the boundary cheap to try. Holds of CONV_CYC-1, CONV_CYC and CONV_CYC+1 or more cycles reach the error, clean and sleep outcomes in turn. The 13-bit level buses let the sweep present levels above full scale and differences that go negative. Each of about a hundred conversions rotates through all four configurations, so every one of them governs the word that follows a change.

// File: rtl/conv_port_emu.sv
module conv_port_emu #(
  parameter int RES      = 12,
  parameter int CONV_CYC = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           conv,
  input  logic           sck,
  input  logic           sdi,
  input  logic [RES:0]   ch0_lvl,
  input  logic [RES:0]   ch1_lvl,
  output logic           sdo,
  output logic           sdo_oe,
  output logic           sleep,
  output logic           early_err
);

  localparam int CW = $clog2(CONV_CYC + 1);

  logic           conv_q, sck_q;
  logic           busy;
  logic [CW-1:0]  cnt;
  logic [RES-1:0] pend, result, shreg, sample_code;
  logic           sgl, odd, stage;
  logic [1:0]     ncfg;
  logic [RES:0]   pos_l, neg_l;
  logic [RES+1:0] diff;

  wire conv_rise = conv & ~conv_q;
  wire conv_fall = ~conv & conv_q;
  wire sck_rise  = sck & ~sck_q;
  wire sck_fall  = ~sck & sck_q;
  wire finishing = busy && (cnt == '0);

  assign pos_l = odd ? ch1_lvl : ch0_lvl;
  assign neg_l = sgl ? '0 : (odd ? ch0_lvl : ch1_lvl);
  assign diff  = {1'b0, pos_l} - {1'b0, neg_l};

  always_comb begin
    if (diff[RES+1])  sample_code = '0;
    else if (diff[RES]) sample_code = '1;
    else              sample_code = diff[RES-1:0];
  end

  assign sdo = sdo_oe & shreg[RES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_q    <= 1'b0;
      sck_q     <= 1'b0;
      busy      <= 1'b0;
      cnt       <= '0;
      pend      <= '0;
      result    <= '0;
      shreg     <= '0;
      sgl       <= 1'b1;
      odd       <= 1'b0;
      stage     <= 1'b0;
      ncfg      <= 2'd0;
      sdo_oe    <= 1'b0;
      sleep     <= 1'b0;
      early_err <= 1'b0;
    end else begin
      conv_q <= conv;
      sck_q  <= sck;
      if (conv_rise) begin
        pend      <= sample_code;
        busy      <= 1'b1;
        cnt       <= CW'(CONV_CYC - 1);
        sdo_oe    <= 1'b0;
        sleep     <= 1'b0;
        early_err <= 1'b0;
      end else if (conv_fall) begin
        sdo_oe    <= 1'b1;
        sleep     <= 1'b0;
        busy      <= 1'b0;
        early_err <= busy & ~finishing;
        shreg     <= finishing ? pend : result;
        if (finishing) result <= pend;
        ncfg      <= 2'd0;
      end else begin
        if (busy) begin
          if (finishing) begin
            busy   <= 1'b0;
            result <= pend;
            sleep  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        if (sdo_oe && sck_fall) shreg <= {shreg[RES-2:0], 1'b0};
        if (sdo_oe && sck_rise && ncfg != 2'd2) begin
          if (ncfg == 2'd0) begin
            stage <= sdi;
          end else begin
            sgl <= stage;
            odd <= sdi;
          end
          ncfg <= ncfg + 2'd1;
        end
      end
    end
  end

endmodule

// File: rtl/conv_port_emu_chk.sv
module conv_port_emu_chk (
  input logic clk,
  input logic rst_n,
  input logic conv,
  input logic sck,
  input logic sdo,
  input logic sdo_oe,
  input logic sleep,
  input logic early_err
);

  AST_OE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv) |=> sdo_oe); // R3

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo); // R3

  AST_SLEEP_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> $past(conv)); // R2

  AST_SLEEP_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sleep && sdo_oe)); // R2

  AST_ERR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(early_err) |-> (!$past(conv) && $past(conv, 2))); // R9

  AST_SDO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(sdo_oe) && !($past(sck, 2) && !$past(sck))) |-> $stable(sdo)); // R4

endmodule

bind conv_port_emu conv_port_emu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .conv(conv), .sck(sck),
  .sdo(sdo), .sdo_oe(sdo_oe), .sleep(sleep), .early_err(early_err)
);

// File: tb/test_conv_port_emu.sv
module test_conv_port_emu;
  localparam int RES      = 12;
  localparam int CONV_CYC = 8;
  localparam time CLK_PER = 10ns;

  logic clk = 1'b0, rst_n = 1'b0, conv = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic [RES:0] ch0_lvl = '0, ch1_lvl = '0;
  logic sdo, sdo_oe, sleep, early_err;

  int nchk = 0, nfail = 0;
  bit finished = 0;
  bit cur_sgl = 1, cur_odd = 0;
  int last_code = 0;

  always #(CLK_PER/2) clk = ~clk;

  conv_port_emu #(.RES(RES), .CONV_CYC(CONV_CYC)) i_conv_port_emu (
    .clk(clk), .rst_n(rst_n), .conv(conv), .sck(sck), .sdi(sdi),
    .ch0_lvl(ch0_lvl), .ch1_lvl(ch1_lvl),
    .sdo(sdo), .sdo_oe(sdo_oe), .sleep(sleep), .early_err(early_err));

  task automatic tick(); @(negedge clk); endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model(bit s, bit o, int a, int b);
    int p, n, d;
    p = o ? b : a;
    n = s ? 0 : (o ? a : b);
    d = p - n;
    if (d < 0) d = 0;
    if (d > 4095) d = 4095;
    return d;
  endfunction

  task automatic txn(input bit ns, input bit no, input int a, input int b,
                     input int hold, input bit first);
    int exp, word;
    bit want_err;
    ch0_lvl = a[RES:0]; ch1_lvl = b[RES:0];
    conv = 1'b1;
    exp = model(cur_sgl, cur_odd, a, b);
    tick();
    ch0_lvl = ~ch0_lvl; ch1_lvl = ch1_lvl ^ 13'h0a5a;
    check(!sdo_oe && !sdo, "R3", {sdo_oe, sdo}, 0);
    repeat (hold - 1) tick();
    if (hold > CONV_CYC) check(sleep == 1'b1, "R2", sleep, 1);
    else check(sleep == 1'b0, "R2", sleep, 0);
    conv = 1'b0;
    tick();
    want_err = (hold < CONV_CYC);
    check(sdo_oe == 1'b1, "R3", sdo_oe, 1);
    check(sleep == 1'b0, "R2", sleep, 0);
    check(early_err == want_err, want_err ? "R9" : "R1", early_err, want_err);
    if (want_err) exp = last_code; else last_code = exp;
    word = int'(sdo);
    check(sdo == exp[11], "R4", sdo, exp[11]);
    for (int j = 1; j <= 13; j++) begin
      sck = 1'b1;
      sdi = (j == 1) ? ns : (j == 2) ? no : j[0];
      tick(); tick();
      sck = 1'b0;
      tick(); tick();
      if (j <= 11) begin
        word = (word << 1) | int'(sdo);
        check(sdo == exp[11-j], "R4", sdo, exp[11-j]);
      end else begin
        check(sdo == 1'b0, "R5", sdo, 0);
      end
    end
    if (first) check(word == exp, "R10", word, exp);
    else if (!want_err) check(word == exp, "R6", word, exp);
    check(word == exp, "R8", word, exp);
    if (!want_err && model(ns, no, a, b) != exp)
      check(word != model(ns, no, a, b), "R7", word, model(ns, no, a, b));
    cur_sgl = ns; cur_odd = no;
  endtask

  initial begin
    repeat (3) tick();
    check(!sdo_oe && !sdo && !sleep && !early_err, "R10",
          {sdo_oe, sdo, sleep, early_err}, 0);
    rst_n = 1'b1;
    tick();
    txn(1'b0, 1'b0, 1234, 77, CONV_CYC + 1, 1'b1);
    txn(1'b0, 1'b1, 100, 900, CONV_CYC, 1'b0);
    txn(1'b1, 1'b1, 300, 2000, CONV_CYC - 1, 1'b0);
    txn(1'b1, 1'b0, 8191, 8191, CONV_CYC + 2, 1'b0);
    txn(1'b1, 1'b1, 0, 5000, CONV_CYC, 1'b0);
    txn(1'b0, 1'b0, 4095, 0, CONV_CYC + 1, 1'b0);
    for (int k = 0; k < 96; k++) begin
      int a, b, h;
      a = (k * 397 + 13) % 8192;
      b = (k * 911 + 5) % 8192;
      if (k % 3 == 0) b = b % 4096;
      h = (k % 7 == 3) ? CONV_CYC - 1 - (k % 2) : CONV_CYC + (k % 3);
      txn(k[1], k[0] ^ k[2], a, b, h, 1'b0);
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule